// File: doc/BRIEF.md
# Cyclic Burst Transfer Sequencer

This block splits one programmed transfer (a start address and a length in beats) into a series of memory-mapped burst requests. At the same time it drives a streaming-side beat path that carries the same number of beats. A request is a valid/ready handshake carrying an address and a beat count. Every accepted request is later retired by a one-cycle completion pulse. The block counts the bursts still in flight and caps them at a parameter limit.

A transfer runs either once or cyclically. In cyclic mode each finished pass restarts at the start address for as long as the cyclic input stays high. Clearing that input lets the current pass finish and then ends the transfer. Lowering enable aborts the transfer. From then on no new burst or beat is offered, but completions for bursts already issued are still counted. Whole transfers are framed by one start interrupt and one end interrupt, however many passes run. An idle output tells the controlling logic when a new submission will be taken.

Top module: `cyclic_dma_seq`

## Requirements
- R1: After reset, idle is 1 and req_valid, beat_valid, sot_irq and eot_irq are 0.
- R2: Each request carries req_beats = min(beats still to request in the pass, MAX_BURST), so only the last burst of a pass is shorter. req_addr starts at the pass start address and advances by req_beats*BEAT_BYTES after each accepted request. Requests hold their address and beat count while waiting for req_ready.
- R3: The in-flight count rises on an accepted request and falls on a completion pulse, and is unchanged when both happen in one cycle. req_valid stays low while the count equals MAX_OUT.
- R4: beat_valid is high while the block is running, enable is high and beats remain in the current pass. Each pass delivers exactly `length` beats.
- R5: A pass ends in the cycle in which all its beats have been requested and streamed and no burst is in flight. If cyclic is low then, the transfer stops and eot_irq pulses high in the following cycle.
- R6: If cyclic is high at the end of a pass, a new pass starts from the original start address and length in the next cycle, and no eot_irq is raised.
- R7: Clearing cyclic during a pass lets that pass complete, followed by exactly one eot_irq and no further pass.
- R8: sot_irq pulses for one cycle in the cycle after a submission is accepted. A cyclic run raises exactly one sot_irq in total.
- R9: While enable is low, req_valid and beat_valid are 0, the transfer stops without an eot_irq, and completions for bursts already issued are still counted.
- R10: idle = (enable low or no transfer running) and in-flight count zero.
- R11: A submission is accepted only when submit, enable and idle are all 1 and length is nonzero. Otherwise it has no effect, and in particular it does not alter a running transfer's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low aborts gracefully |
| cyclic | input | 1 | Repeat passes while high |
| submit | input | 1 | Submission strobe |
| start_addr | input | ADDR_W | Start address of the transfer |
| length | input | LEN_W | Transfer length in beats |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | ADDR_W | Burst start address |
| req_beats | output | BURST_W | Burst beat count |
| rsp_valid | input | 1 | One burst completed |
| beat_valid | output | 1 | Streaming beat valid |
| beat_ready | input | 1 | Streaming beat accepted |
| sot_irq | output | 1 | Start-of-transfer pulse |
| eot_irq | output | 1 | End-of-transfer pulse |
| idle | output | 1 | Ready for a new submission |

## Verification
The outputs req_valid, req_addr, req_beats, beat_valid and idle are combinational on the registered state and on enable. They are therefore due in the cycle in which their cause is registered. sot_irq and eot_irq are registered and are due one cycle after the accepted submission or the end of a pass. The in-flight count shows up one cycle after a handshake, through req_valid and idle. The bench drives its inputs at the falling edge, samples 1 ns later and compares every output against its behavioural model on every cycle. It advances the model on the rising edge, so each result is compared in exactly the cycle in which it is due.

// File: rtl/cyclic_dma_seq.sv
module cyclic_dma_seq #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 16,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_OUT    = 4,
  localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cyclic,
  input  logic               submit,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [LEN_W-1:0]   length,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  input  logic               rsp_valid,
  output logic               beat_valid,
  input  logic               beat_ready,
  output logic               sot_irq,
  output logic               eot_irq,
  output logic               idle
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  logic              running;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [LEN_W-1:0]  total_q, req_left, beat_left;
  logic [OUT_W-1:0]  out_cnt;

  wire req_fire  = req_valid && req_ready;
  wire beat_fire = beat_valid && beat_ready;
  wire rsp_take  = rsp_valid && (out_cnt != '0);
  wire pass_done = running && enable && (req_left == '0) && (beat_left == '0) && (out_cnt == '0);
  wire accept    = submit && enable && idle && (length != '0);

  assign idle       = (!enable || !running) && (out_cnt == '0);
  assign req_valid  = running && enable && (req_left != '0) && (out_cnt != OUT_W'(MAX_OUT));
  assign beat_valid = running && enable && (beat_left != '0);
  assign req_addr   = addr_q;
  assign req_beats  = (req_left > LEN_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : req_left[BURST_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
    end else if (req_fire && !rsp_take) begin
      out_cnt <= out_cnt + 1'b1;
    end else if (rsp_take && !req_fire) begin
      out_cnt <= out_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      base_q    <= '0;
      addr_q    <= '0;
      total_q   <= '0;
      req_left  <= '0;
      beat_left <= '0;
      sot_irq   <= 1'b0;
      eot_irq   <= 1'b0;
    end else begin
      sot_irq <= accept;
      eot_irq <= pass_done && !cyclic;
      if (!enable) begin
        running <= 1'b0;
      end else if (accept) begin
        running   <= 1'b1;
        base_q    <= start_addr;
        addr_q    <= start_addr;
        total_q   <= length;
        req_left  <= length;
        beat_left <= length;
      end else if (pass_done) begin
        if (cyclic) begin
          addr_q    <= base_q;
          req_left  <= total_q;
          beat_left <= total_q;
        end else begin
          running <= 1'b0;
        end
      end else begin
        if (req_fire) begin
          addr_q   <= addr_q + ADDR_W'(req_beats) * ADDR_W'(BEAT_BYTES);
          req_left <= req_left - LEN_W'(req_beats);
        end
        if (beat_fire) beat_left <= beat_left - 1'b1;
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OUT_W'(MAX_OUT));
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!enable || (req_valid && $stable(req_addr) && $stable(req_beats))));
  assert_burst_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0) && (req_beats <= BURST_W'(MAX_BURST)));
  assert_no_eot_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !eot_irq);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!req_valid && !beat_valid));
  assert_eot_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eot_irq |-> idle);
  assert_irq_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sot_irq && eot_irq));
endmodule

// File: tb/sim_cyclic_dma_seq.sv
module sim_cyclic_dma_seq;
  localparam int MB = 16, BB = 4, MAXO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, cyclic = 1'b0, submit = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] length = '0;
  logic req_valid, req_ready = 1'b0, rsp_valid = 1'b0, beat_valid, beat_ready = 1'b0;
  logic [31:0] req_addr;
  logic [4:0] req_beats;
  logic sot_irq, eot_irq, idle;

  cyclic_dma_seq u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cyclic(cyclic), .submit(submit),
    .start_addr(start_addr), .length(length), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .rsp_valid(rsp_valid),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .sot_irq(sot_irq),
    .eot_irq(eot_irq), .idle(idle));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc_n = 0;
  bit rr_all = 0, rsp_on = 1, done_flag = 0;
  int m_run = 0, m_base = 0, m_tot = 0, m_addr = 0, m_rl = 0, m_bl = 0, m_out = 0;
  int m_sot = 0, m_eot = 0, m_passes = 0;
  int m_idle, m_rv, m_rb, m_bv;
  int sot_seen = 0, eot_seen = 0, addr_lo = 0, addr_hi = 32'h7fffffff, bad_addr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc_n);
    end
  endtask

  task automatic step(input bit s);
    int acc, rf, bf, rt, dn;
    @(negedge clk);
    cyc_n++;
    submit     = s;
    req_ready  = rr_all ? 1'b1 : (cyc_n % 3 != 0);
    beat_ready = (cyc_n % 4 != 1);
    rsp_valid  = rsp_on && (m_out > 0) && (cyc_n % 2 == 0);
    m_idle = ((!enable) || m_run == 0) && m_out == 0;
    m_rv   = m_run != 0 && enable && m_rl > 0 && m_out < MAXO;
    m_rb   = (m_rl > MB) ? MB : m_rl;
    m_bv   = m_run != 0 && enable && m_bl > 0;
    #1;
    check(idle == m_idle, "R10 idle", idle, m_idle);
    check(req_valid == m_rv, "R3 req_valid", req_valid, m_rv);
    if (m_rv) begin
      check(req_addr == m_addr, "R2 req_addr", req_addr, m_addr);
      check(req_beats == m_rb, "R2 req_beats", req_beats, m_rb);
      if (req_addr < addr_lo || req_addr >= addr_hi) bad_addr++;
    end
    check(beat_valid == m_bv, "R4 beat_valid", beat_valid, m_bv);
    check(sot_irq == m_sot, "R8 sot_irq", sot_irq, m_sot);
    check(eot_irq == m_eot, "R5 eot_irq", eot_irq, m_eot);
    if (sot_irq) sot_seen++;
    if (eot_irq) eot_seen++;
    @(posedge clk);
    acc = s && enable && m_idle && length != 0;
    rf  = m_rv && req_ready;
    bf  = m_bv && beat_ready;
    rt  = rsp_valid && m_out > 0;
    dn  = m_run != 0 && enable && m_rl == 0 && m_bl == 0 && m_out == 0;
    m_out = m_out + rf - rt;
    m_sot = acc;
    m_eot = dn && !cyclic;
    if (!enable) m_run = 0;
    else if (acc) begin
      m_run = 1; m_base = start_addr; m_tot = length;
      m_addr = start_addr; m_rl = length; m_bl = length;
    end else if (dn) begin
      m_passes++;
      if (cyclic) begin m_addr = m_base; m_rl = m_tot; m_bl = m_tot; end
      else m_run = 0;
    end else begin
      if (rf) begin m_addr = m_addr + m_rb * BB; m_rl = m_rl - m_rb; end
      if (bf) m_bl = m_bl - 1;
    end
    #2;
  endtask

  task automatic run_to_idle(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (m_run == 0 && m_out == 0) break;
      step(0);
    end
  endtask

  task automatic oneshot(input int a, input int len);
    int e0;
    e0 = eot_seen;
    start_addr = a; length = len[15:0]; cyclic = 0;
    step(1);
    run_to_idle(2000);
    step(0); step(0);
    check(eot_seen - e0 == 1, "R5 one eot per one-shot", eot_seen - e0, 1);
  endtask

  initial begin
    #1;
    repeat (2) @(negedge clk);
    #1;
    check(idle == 1 && !req_valid && !beat_valid && !sot_irq && !eot_irq,
          "R1 reset outputs", {idle, req_valid, beat_valid, sot_irq, eot_irq}, 5'b10000);
    @(negedge clk); rst_n = 1; enable = 1;
    @(posedge clk); #2;

    oneshot(32'h100, 40);
    oneshot(32'h400, 16);
    oneshot(32'h800, 5);
    rr_all = 1;
    oneshot(32'h2000, 33);
    rr_all = 0;

    start_addr = 32'h3000; length = 0;
    step(1); step(0);
    check(m_run == 0 && idle == 1 && sot_seen == 4, "R11 zero length ignored", sot_seen, 4);

    sot_seen = 0; eot_seen = 0;
    addr_lo = 32'h1000; addr_hi = 32'h1000 + 20 * BB;
    start_addr = 32'h1000; length = 20; cyclic = 1;
    step(1);
    m_passes = 0;
    for (int i = 0; i < 3000 && m_passes < 3; i++) begin
      if (i == 7) begin start_addr = 32'h9000; length = 7; step(1); end
      else step(0);
    end
    check(m_passes >= 3, "R6 cyclic restarts", m_passes, 3);
    check(eot_seen == 0, "R6 no eot between passes", eot_seen, 0);
    for (int i = 0; i < 5; i++) step(0);
    cyclic = 0;
    run_to_idle(2000);
    step(0); step(0);
    check(eot_seen == 1, "R7 single eot after clearing cyclic", eot_seen, 1);
    check(sot_seen == 1, "R8 single sot for cyclic run", sot_seen, 1);
    check(bad_addr == 0, "R11 submit while active ignored", bad_addr, 0);
    addr_lo = 0; addr_hi = 32'h7fffffff;

    rr_all = 1; rsp_on = 0; eot_seen = 0;
    start_addr = 32'h5000; length = 100;
    step(1);
    for (int i = 0; i < 8; i++) step(0);
    check(req_valid == 0 && m_out == MAXO, "R3 request held at limit", req_valid, 0);
    enable = 0;
    for (int i = 0; i < 4; i++) step(0);
    check(idle == 0 && beat_valid == 0 && req_valid == 0, "R9 abort waits for bursts", idle, 0);
    rsp_on = 1;
    run_to_idle(200);
    step(0);
    check(idle == 1 && eot_seen == 0, "R9 idle after drain without eot", idle, 1);
    enable = 1; rr_all = 0;
    oneshot(32'h6000, 18);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule